// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block merges sixteen level-sensitive interrupt request lines into one interrupt signal for a processor, along with an eight-bit vector number. Internally it works as two eight-input priority controllers. The interrupt of the secondary controller feeds input 2 of the primary controller. As a result, the whole secondary group takes the priority slot of primary input 2.

Software unmasks lines through a mask write port. The processor then answers an asserted `int_o` with an acknowledge pulse. On that acknowledge the block records the winning line as in service and presents its vector on the next cycle. An end-of-interrupt pulse retires the highest-priority line that is in service. Line 9 can optionally be reported with the vector of line 2.

Top module: `cascade_pic`

## Requirements
- R1: After reset, all sixteen mask bits are set, no line is in service, `int_o` is low and `vector_o` is 00h.
- R2: A one-cycle `mask_we_i` pulse loads `mask_wdata_i` into the mask (bit n set masks line n). A masked line never raises `int_o`. Clearing its bit lets an asserted line raise `int_o`.
- R3: Among lines 0–7, a lower number wins. Primary line n is delivered with vector 08h+n.
- R4: Among lines 8–15, a lower number wins. Secondary line n is delivered with vector 70h+(n−8). The secondary group reaches the processor only while mask bit 2 is clear.
- R5: The overall priority order is 0, 1, 8, 9, …, 15, 3, 4, 5, 6, 7.
- R6: While `redirect_en_i` is high, line 9 is delivered with vector 0Ah. While it is low, line 9 is delivered with vector 71h.
- R7: An acknowledge sampled while `int_o` is high does two things. It marks the winning line in service, and `vector_o` shows that line's vector from the next cycle on. An acknowledge while `int_o` is low leaves `vector_o` and the in-service state unchanged.
- R8: A line in service blocks itself and every lower-priority line. A strictly higher-priority request still raises `int_o`. A secondary line in service also holds primary input 2 in service, which blocks the whole secondary group.
- R9: An end-of-interrupt retires the highest-priority line in service. When that line is secondary, primary input 2 is also retired once no secondary line remains in service.
- R10: Request input 2 has no effect, because that primary input carries the cascade.
- R11: Requests are levels. Dropping an unacknowledged request drops `int_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Request lines, level-sensitive, active high |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 16 | New mask value |
| redirect_en_i | input | 1 | Report line 9 with the vector of line 2 |
| int_o | output | 1 | Interrupt to the processor |
| ack_i | input | 1 | Interrupt acknowledge, one cycle |
| vector_o | output | 8 | Vector of the last acknowledged line |
| eoi_i | input | 1 | End-of-interrupt, one cycle |

## Verification
The bench builds the block with its default parameters: eight lines per controller, the cascade on primary input 2, and vector bases 08h and 70h, with line 9 as the line that can be redirected. With these values the bench can drive every interleaving of the two halves: a secondary request beating primary lines 3–7, losing to lines 0 and 1, and being blocked as a group while the cascade input is in service. The nested end-of-interrupt order and both settings of the line 9 redirect are also covered.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
    localparam int CPIC_LINES      = 8;
    localparam int CPIC_VEC_W      = 8;
    localparam int CPIC_CASC_INPUT = 2;
    localparam logic [7:0] CPIC_PRI_BASE  = 8'h08;
    localparam logic [7:0] CPIC_SEC_BASE  = 8'h70;
    localparam int CPIC_REDIR_LOCAL = 1;      // secondary local index of line 9
    localparam logic [7:0] CPIC_REDIR_VEC = 8'h0A;

    typedef enum logic { CTRL_PRI = 1'b0, CTRL_SEC = 1'b1 } ctrl_e;
endpackage

// File: rtl/cpic_resolver.sv
module cpic_resolver #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    input  logic [N-1:0]     isr_i,
    output logic             grant_o,
    output logic [IDX_W-1:0] grant_idx_o,
    output logic             busy_o,
    output logic [IDX_W-1:0] busy_idx_o
);
    // highest-priority (lowest index) line in service
    always_comb begin
        busy_o     = 1'b0;
        busy_idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (isr_i[i]) begin
                busy_o     = 1'b1;
                busy_idx_o = IDX_W'(i);
            end
        end
    end

    // highest-priority request that outranks everything in service
    always_comb begin
        grant_o     = 1'b0;
        grant_idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i] && (!busy_o || (IDX_W'(i) < busy_idx_o))) begin
                grant_o     = 1'b1;
                grant_idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/cpic_vector.sv
module cpic_vector #(
    parameter int N          = 8,
    parameter int IDX_W      = $clog2(N),
    parameter int VEC_W      = 8,
    parameter int CASC       = 2,
    parameter int REDIR      = 1,
    parameter logic [VEC_W-1:0] PRI_BASE  = 8'h08,
    parameter logic [VEC_W-1:0] SEC_BASE  = 8'h70,
    parameter logic [VEC_W-1:0] REDIR_VEC = 8'h0A
) (
    input  logic [IDX_W-1:0] pri_idx_i,
    input  logic [IDX_W-1:0] sec_idx_i,
    input  logic             redirect_en_i,
    output logic [VEC_W-1:0] vec_o
);
    always_comb begin
        if (pri_idx_i == IDX_W'(CASC)) begin
            if (redirect_en_i && (sec_idx_i == IDX_W'(REDIR))) begin
                vec_o = REDIR_VEC;
            end else begin
                vec_o = SEC_BASE + VEC_W'(sec_idx_i);
            end
        end else begin
            vec_o = PRI_BASE + VEC_W'(pri_idx_i);
        end
    end
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
    import cpic_pkg::*;
#(
    parameter int N     = CPIC_LINES,
    parameter int VEC_W = CPIC_VEC_W,
    parameter int CASC  = CPIC_CASC_INPUT,
    parameter int REDIR = CPIC_REDIR_LOCAL,
    parameter logic [VEC_W-1:0] PRI_BASE  = CPIC_PRI_BASE,
    parameter logic [VEC_W-1:0] SEC_BASE  = CPIC_SEC_BASE,
    parameter logic [VEC_W-1:0] REDIR_VEC = CPIC_REDIR_VEC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*N-1:0]     irq_i,
    input  logic               mask_we_i,
    input  logic [2*N-1:0]     mask_wdata_i,
    input  logic               redirect_en_i,
    output logic               int_o,
    input  logic               ack_i,
    output logic [VEC_W-1:0]   vector_o,
    input  logic               eoi_i
);
    localparam int TOTAL = 2 * N;
    localparam int IDX_W = $clog2(N);

    typedef struct packed {
        logic [TOTAL-1:0] mask;
        logic [TOTAL-1:0] isr;
        logic [VEC_W-1:0] vec;
    } state_t;

    state_t state_d, state_q;

    logic [TOTAL-1:0] mask_q;
    logic [TOTAL-1:0] isr_q;
    assign mask_q = state_q.mask;
    assign isr_q  = state_q.isr;

    logic [1:0][N-1:0]     req_arr;
    logic [1:0][N-1:0]     isr_arr;
    logic [1:0]            grant;
    logic [1:0][IDX_W-1:0] grant_idx;
    logic [1:0]            busy;
    logic [1:0][IDX_W-1:0] busy_idx;
    logic [VEC_W-1:0]      win_vec;

    // secondary sees its own masked lines; primary input CASC carries the cascade
    always_comb begin
        req_arr[CTRL_SEC] = irq_i[TOTAL-1:N] & ~state_q.mask[TOTAL-1:N];
        req_arr[CTRL_PRI] = irq_i[N-1:0] & ~state_q.mask[N-1:0];
        req_arr[CTRL_PRI][CASC] = grant[CTRL_SEC] & ~state_q.mask[CASC];
        isr_arr[CTRL_PRI] = state_q.isr[N-1:0];
        isr_arr[CTRL_SEC] = state_q.isr[TOTAL-1:N];
    end

    for (genvar g = 0; g < 2; g++) begin : g_ctrl
        cpic_resolver #(.N(N), .IDX_W(IDX_W)) u_res (
            .req_i       (req_arr[g]),
            .isr_i       (isr_arr[g]),
            .grant_o     (grant[g]),
            .grant_idx_o (grant_idx[g]),
            .busy_o      (busy[g]),
            .busy_idx_o  (busy_idx[g])
        );
    end

    cpic_vector #(
        .N(N), .IDX_W(IDX_W), .VEC_W(VEC_W), .CASC(CASC), .REDIR(REDIR),
        .PRI_BASE(PRI_BASE), .SEC_BASE(SEC_BASE), .REDIR_VEC(REDIR_VEC)
    ) u_vec (
        .pri_idx_i     (grant_idx[CTRL_PRI]),
        .sec_idx_i     (grant_idx[CTRL_SEC]),
        .redirect_en_i (redirect_en_i),
        .vec_o         (win_vec)
    );

    assign int_o    = grant[CTRL_PRI];
    assign vector_o = state_q.vec;

    always_comb begin
        state_d = state_q;

        if (mask_we_i) begin
            state_d.mask = mask_wdata_i;
        end

        // end-of-interrupt: retire the top line in overall order
        if (eoi_i && busy[CTRL_PRI]) begin
            if (busy_idx[CTRL_PRI] == IDX_W'(CASC)) begin
                if (busy[CTRL_SEC]) begin
                    state_d.isr[N + int'(busy_idx[CTRL_SEC])] = 1'b0;
                end
                if (state_d.isr[TOTAL-1:N] == '0) begin
                    state_d.isr[CASC] = 1'b0;
                end
            end else begin
                state_d.isr[busy_idx[CTRL_PRI]] = 1'b0;
            end
        end

        // acknowledge: latch vector and mark in service
        if (ack_i && grant[CTRL_PRI]) begin
            state_d.vec = win_vec;
            state_d.isr[grant_idx[CTRL_PRI]] = 1'b1;
            if (grant_idx[CTRL_PRI] == IDX_W'(CASC)) begin
                state_d.isr[N + int'(grant_idx[CTRL_SEC])] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.mask <= '1;
            state_q.isr  <= '0;
            state_q.vec  <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/cascade_pic_chk.sv
module cascade_pic_chk #(
    parameter int N     = 8,
    parameter int VEC_W = 8,
    parameter int CASC  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_o,
    input logic             ack_i,
    input logic             eoi_i,
    input logic [VEC_W-1:0] vector_o,
    input logic [2*N-1:0]   mask_q,
    input logic [2*N-1:0]   isr_q
);
    localparam int TOTAL = 2 * N;

    assert_mask_all_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !int_o);

    assert_ack_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o && !eoi_i) |=> ($countones(isr_q) > $past($countones(isr_q))));

    assert_vector_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && int_o) |=> $stable(vector_o));

    assert_cascade_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|isr_q[TOTAL-1:N]) |-> isr_q[CASC]);

    assert_eoi_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !ack_i && (|isr_q)) |=> ($countones(isr_q) < $past($countones(isr_q))));
endmodule

bind cascade_pic cascade_pic_chk #(.N(N), .VEC_W(VEC_W), .CASC(CASC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_o    (int_o),
    .ack_i    (ack_i),
    .eoi_i    (eoi_i),
    .vector_o (vector_o),
    .mask_q   (mask_q),
    .isr_q    (isr_q)
);

// File: tb/cascade_pic_tb.sv
`timescale 1ns/1ps
module cascade_pic_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_i = '0;
    logic        mask_we_i = 1'b0;
    logic [15:0] mask_wdata_i = '0;
    logic        redirect_en_i = 1'b0;
    logic        int_o;
    logic        ack_i = 1'b0;
    logic [7:0]  vector_o;
    logic        eoi_i = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    cascade_pic u_dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .mask_we_i(mask_we_i),
        .mask_wdata_i(mask_wdata_i), .redirect_en_i(redirect_en_i),
        .int_o(int_o), .ack_i(ack_i), .vector_o(vector_o), .eoi_i(eoi_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops the expected vector when an accepted acknowledge occurs
    always @(posedge clk) begin
        if (rst_n && ack_i && int_o) begin
            #2;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected ack", vector_o, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(vector_o == e, t, vector_o, e);
            end
        end
    end

    task automatic set_irq(input logic [15:0] v);
        @(negedge clk);
        irq_i = v;
    endtask

    task automatic wr_mask(input logic [15:0] v);
        @(negedge clk);
        mask_we_i = 1'b1;
        mask_wdata_i = v;
        @(negedge clk);
        mask_we_i = 1'b0;
    endtask

    task automatic chk_int(input bit exp, input string req);
        @(negedge clk);
        check(int_o == exp, req, int_o, exp);
    endtask

    task automatic do_ack(input logic [7:0] exp, input string req);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic do_eoi();
        @(negedge clk);
        eoi_i = 1'b1;
        @(negedge clk);
        eoi_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(int_o == 1'b0, "R1 int_o", int_o, 0);
        check(vector_o == 8'h00, "R1 vector_o", vector_o, 0);
        set_irq(16'hFFFF);
        chk_int(1'b0, "R1 all masked");

        // R2 mask write
        wr_mask(16'hFFFF & ~16'h0020);
        set_irq(16'h0020);
        chk_int(1'b1, "R2 unmasked line 5");
        do_ack(8'h0D, "R3 vector line 5");
        do_eoi();
        set_irq(16'h0000);
        wr_mask(16'h0000);
        set_irq(16'h0040);
        wr_mask(16'h0040);
        chk_int(1'b0, "R2 masked line 6");
        wr_mask(16'h0000);
        chk_int(1'b1, "R2 line 6 unmasked");
        // R11 level sensitivity
        set_irq(16'h0000);
        chk_int(1'b0, "R11 dropped request");

        // R3 primary priority and R8 nesting
        set_irq(16'h0048);
        do_ack(8'h0B, "R3 line 3 beats 6");
        chk_int(1'b0, "R8 line 3 in service blocks");
        set_irq(16'h004A);
        chk_int(1'b1, "R8 line 1 preempts");
        do_ack(8'h09, "R3 line 1 vector");
        set_irq(16'h0058);
        chk_int(1'b0, "R8 both in service");
        do_eoi();
        chk_int(1'b0, "R9 line 3 still in service");
        set_irq(16'h0050);
        do_eoi();
        chk_int(1'b1, "R9 line 3 retired");
        do_ack(8'h0C, "R3 line 4 vector");
        do_eoi();
        set_irq(16'h0000);

        // R5 / R4 cascade
        set_irq(16'h1008);
        do_ack(8'h74, "R5 line 12 beats 3");
        chk_int(1'b0, "R8 cascade in service");
        set_irq(16'h1108);
        chk_int(1'b0, "R8 line 8 blocked by cascade");
        do_eoi();
        chk_int(1'b1, "R9 cascade retired");
        do_ack(8'h70, "R4 line 8 vector");
        do_eoi();
        set_irq(16'h8010);
        do_ack(8'h77, "R4 line 15 beats 4");
        do_eoi();
        set_irq(16'h0102);
        do_ack(8'h09, "R5 line 1 beats 8");
        do_eoi();
        set_irq(16'h0000);

        // R4 cascade mask gating
        wr_mask(16'h0004);
        set_irq(16'h0200);
        chk_int(1'b0, "R4 cascade input masked");
        wr_mask(16'h0000);
        chk_int(1'b1, "R4 cascade input unmasked");

        // R6 redirect
        do_ack(8'h71, "R6 line 9 without redirect");
        do_eoi();
        @(negedge clk);
        redirect_en_i = 1'b1;
        do_ack(8'h0A, "R6 line 9 redirected");
        do_eoi();
        set_irq(16'h0000);

        // R7 ignored acknowledge
        chk_int(1'b0, "R7 idle");
        @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        check(vector_o == 8'h0A, "R7 vector held", vector_o, 8'h0A);
        set_irq(16'h0080);
        chk_int(1'b1, "R7 nothing marked by ignored ack");
        set_irq(16'h0000);

        // R10 cascade pin ignored
        set_irq(16'h0004);
        chk_int(1'b0, "R10 request input 2");
        set_irq(16'h0000);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
        finish_run();
    end
endmodule